// File: doc/BRIEF.md
# Region Buffer and Dual-Link Event Serializer

This block sits between the per-channel hit capture stages of a 64-channel strip readout chip and its two output data links. The channels are split into groups of eight called regions. Each region takes at most one validated hit per clock from its channels, chosen in rotating order, and holds it in a small local FIFO. Each hit carries a 10-bit arrival time and a 10-bit time-over-threshold value. A valid/ready handshake on each channel tells the capture stage when its hit has been taken. A channel with a pending hit holds it until it sees ready.

A global controller visits the non-empty regions in rotating order. It builds one 32-bit event word for each hit and hands the word to a free serial link. Each link shifts its word out MSB first, one bit per clock. There is no trigger: a stored hit leaves as soon as a link can take it.

When a region's FIFO is full, its channels are stalled. The number of stalled clock edges is recorded in the next word that region produces, so that congestion can be seen downstream.

Top module: `region_link_top`

## Requirements
- R1: Each event word, MSB first, holds: bit 31 = 1 (start marker), bits 30:25 = channel number (region index × 8 + local index), bits 24:15 = arrival time, bits 14:5 = time-over-threshold, bits 4:1 = region stall count, bit 0 = parity.
- R2: The parity bit makes the XOR of all 32 bits of a word equal to 0.
- R3: A link with no word to send drives 0. A word occupies exactly 32 consecutive cycles on one link. Consecutive words on the same link are separated by at least one idle cycle.
- R4: A new word goes to the lowest-numbered idle link, so link 0 is used when both links are idle. At most one word starts per cycle.
- R5: Suppose a hit is accepted at a clock edge while its region FIFO is empty and a link is idle. Then its start marker appears on the link in the cycle that follows the next clock edge.
- R6: Within a region, at most one channel sees ready per cycle, and only a channel that presents a hit. Channels are served in rotating order starting just after the last channel served. After reset, service starts from local channel 0.
- R7: Each region FIFO holds 4 hits. While it is full, every ready in that region stays low and a pending hit stays pending.
- R8: The global controller serves non-empty regions in rotating order. After reset, it starts from region 0.
- R9: The stall count is the number of clock edges at which the region FIFO was full while at least one of its channels presented a hit. Counting starts from the region's previous accepted hit. The count saturates at 15 and clears when a hit is accepted.
- R10: During reset, both links are 0, and with no hit presented every ready is 0. Every accepted hit appears in exactly one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 64 | Per-channel hit pending |
| hit_toa | input | 640 | Per-channel arrival time, 10 bits per channel, channel c at bits 10c+9:10c |
| hit_tot | input | 640 | Per-channel time-over-threshold, same packing as hit_toa |
| hit_ready | output | 64 | Per-channel hit accepted at this clock edge |
| link_out | output | 2 | Serial data of link 0 and link 1 |

## Verification
The bound checker watches the following on every cycle:
- the handshake rules: one ready per region, ready only for a presented hit, and no ready while the region is full;
- the link framing: an idle link drives 0, and every word opens with the marker;
- the link choice: a load only on an idle link, the lower link first, and one load at a time.

Only the bench scenarios can show the rest:
- the content of the words: field placement, parity and channel numbering;
- the rotating service order inside a region, including its wrap, and among regions;
- the exact start latency and the 33-cycle reuse spacing of a link;
- the saturation of the stall count after a long backlog;
- that each injected hit comes out exactly once.

// File: rtl/rlt_pkg.sv
package rlt_pkg;
    localparam int CH_PER_REGION = 8;
    localparam int LOC_W         = $clog2(CH_PER_REGION);
    localparam int TS_W          = 10;
    localparam int LOSS_W        = 4;
    localparam int CHAN_W        = 6;
    localparam int WORD_W        = 1 + CHAN_W + 2 * TS_W + LOSS_W + 1;

    typedef struct packed {
        logic [LOC_W-1:0]  loc;
        logic [TS_W-1:0]   toa;
        logic [TS_W-1:0]   tot;
        logic [LOSS_W-1:0] loss;
    } entry_t;

    // Build a word: marker, channel, times, stall count, then even parity.
    function automatic logic [WORD_W-1:0] pack_word(input logic [CHAN_W-1:0] chan,
                                                    input entry_t e);
        logic [WORD_W-2:0] body;
        body = {1'b1, chan, e.toa, e.tot, e.loss};
        return {body, ^body};
    endfunction
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] grant_idx,
    output logic          any
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_st_t;

    arb_st_t       st_q, st_d;
    logic [IW-1:0] cand;

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        cand      = '0;
        for (int off = 0; off < N; off++) begin
            cand = IW'((int'(st_q.ptr) + off) % N);
            if (!any && req[cand]) begin
                any       = 1'b1;
                grant_idx = cand;
            end
        end
        if (any) grant[grant_idx] = 1'b1;

        st_d = st_q;
        if (advance && any) begin
            st_d.ptr = (int'(grant_idx) == N - 1) ? '0 : IW'(grant_idx + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/region_buffer.sv
module region_buffer import rlt_pkg::*; #(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CH_PER_REGION-1:0]      ch_valid,
    input  logic [CH_PER_REGION*TS_W-1:0] ch_toa,
    input  logic [CH_PER_REGION*TS_W-1:0] ch_tot,
    output logic [CH_PER_REGION-1:0]      ch_ready,
    input  logic                          pop,
    output entry_t                        head,
    output logic                          not_empty,
    output logic                          full
);
    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]      wr;
        logic [PW-1:0]      rd;
        logic [CW-1:0]      cnt;
        logic [LOSS_W-1:0]  loss;
    } rb_st_t;

    rb_st_t                   st_q, st_d;
    logic [CH_PER_REGION-1:0] arb_req;
    logic [CH_PER_REGION-1:0] arb_grant;
    logic [LOC_W-1:0]         arb_idx;
    logic                     arb_any;
    logic                     do_pop;

    assign full      = (st_q.cnt == CW'(DEPTH));
    assign not_empty = (st_q.cnt != '0);
    assign head      = st_q.mem[st_q.rd];
    assign arb_req   = full ? '0 : ch_valid;
    assign ch_ready  = arb_grant;

    rr_arbiter #(.N(CH_PER_REGION)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (arb_req),
        .advance   (arb_any),
        .grant     (arb_grant),
        .grant_idx (arb_idx),
        .any       (arb_any)
    );

    always_comb begin
        st_d   = st_q;
        do_pop = pop && not_empty;
        if (arb_any) begin
            st_d.mem[st_q.wr] = '{loc:  arb_idx,
                                  toa:  ch_toa[arb_idx*TS_W +: TS_W],
                                  tot:  ch_tot[arb_idx*TS_W +: TS_W],
                                  loss: st_q.loss};
            st_d.wr   = st_q.wr + 1'b1;
            st_d.loss = '0;
        end else if (full && (|ch_valid) && (st_q.loss != '1)) begin
            st_d.loss = st_q.loss + 1'b1;
        end
        if (do_pop) st_d.rd = st_q.rd + 1'b1;
        case ({arb_any, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/link_serializer.sv
module link_serializer #(
    parameter int W = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic         idle,
    output logic         sout
);
    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] cnt;
    } ls_st_t;

    ls_st_t st_q, st_d;

    assign idle = (st_q.cnt == '0);
    assign sout = !idle && st_q.sh[W-1];

    always_comb begin
        st_d = st_q;
        if (!idle) begin
            st_d.sh  = st_q.sh << 1;
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (load) begin
            st_d.sh  = word;
            st_d.cnt = CW'(W);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/region_link_top.sv
module region_link_top import rlt_pkg::*; #(
    parameter int NUM_REGIONS = 8,
    parameter int FIFO_DEPTH  = 4,
    parameter int NUM_LINKS   = 2,
    localparam int NCH = NUM_REGIONS * CH_PER_REGION,
    localparam int RIW = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       hit_valid,
    input  logic [NCH*TS_W-1:0]  hit_toa,
    input  logic [NCH*TS_W-1:0]  hit_tot,
    output logic [NCH-1:0]       hit_ready,
    output logic [NUM_LINKS-1:0] link_out
);
    logic [NUM_REGIONS-1:0] region_nonempty;
    logic [NUM_REGIONS-1:0] region_full;
    logic [NUM_REGIONS-1:0] region_pop;
    entry_t                 region_head [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] g_grant;
    logic [RIW-1:0]         g_idx;
    logic                   g_any;
    logic                   pop_go;
    logic [NUM_LINKS-1:0]   link_idle;
    logic [NUM_LINKS-1:0]   link_load;
    entry_t                 sel_entry;
    logic [WORD_W-1:0]      word;
    logic                   placed;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        region_buffer #(.DEPTH(FIFO_DEPTH)) u_region (
            .clk       (clk),
            .rst_n     (rst_n),
            .ch_valid  (hit_valid[r*CH_PER_REGION +: CH_PER_REGION]),
            .ch_toa    (hit_toa[r*CH_PER_REGION*TS_W +: CH_PER_REGION*TS_W]),
            .ch_tot    (hit_tot[r*CH_PER_REGION*TS_W +: CH_PER_REGION*TS_W]),
            .ch_ready  (hit_ready[r*CH_PER_REGION +: CH_PER_REGION]),
            .pop       (region_pop[r]),
            .head      (region_head[r]),
            .not_empty (region_nonempty[r]),
            .full      (region_full[r])
        );
    end

    rr_arbiter #(.N(NUM_REGIONS)) u_region_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (region_nonempty),
        .advance   (pop_go),
        .grant     (g_grant),
        .grant_idx (g_idx),
        .any       (g_any)
    );

    always_comb begin
        pop_go     = g_any && (|link_idle);
        region_pop = g_grant & {NUM_REGIONS{pop_go}};
        sel_entry  = region_head[g_idx];
        word       = pack_word(CHAN_W'({g_idx, sel_entry.loc}), sel_entry);
        link_load  = '0;
        placed     = 1'b0;
        for (int l = 0; l < NUM_LINKS; l++) begin
            if (pop_go && !placed && link_idle[l]) begin
                link_load[l] = 1'b1;
                placed       = 1'b1;
            end
        end
    end

    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
        link_serializer #(.W(WORD_W)) u_link (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (link_load[l]),
            .word  (word),
            .idle  (link_idle[l]),
            .sout  (link_out[l])
        );
    end
endmodule

// File: rtl/rlt_checker.sv
module rlt_checker #(
    parameter int NUM_REGIONS = 8,
    parameter int NUM_LINKS   = 2,
    parameter int CPR         = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_REGIONS*CPR-1:0] hit_valid,
    input logic [NUM_REGIONS*CPR-1:0] hit_ready,
    input logic [NUM_LINKS-1:0]       link_out,
    input logic [NUM_LINKS-1:0]       link_idle,
    input logic [NUM_LINKS-1:0]       link_load,
    input logic [NUM_REGIONS-1:0]     region_full
);
    p_ready_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_ready & ~hit_valid) == '0);

    p_one_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(link_load));

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rchk
        p_one_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit_ready[r*CPR +: CPR]));
        p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
            region_full[r] |-> (hit_ready[r*CPR +: CPR] == '0));
    end

    for (genvar l = 0; l < NUM_LINKS; l++) begin : g_lchk
        p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
            link_idle[l] |-> !link_out[l]);
        p_start_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(link_idle[l]) |-> link_out[l]);
        p_load_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            link_load[l] |-> link_idle[l]);
        if (l > 0) begin : g_order
            p_lower_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
                link_load[l] |-> !link_idle[l-1]);
        end
    end
endmodule

bind region_link_top rlt_checker #(
    .NUM_REGIONS (NUM_REGIONS),
    .NUM_LINKS   (NUM_LINKS),
    .CPR         (rlt_pkg::CH_PER_REGION)
) u_rlt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_valid   (hit_valid),
    .hit_ready   (hit_ready),
    .link_out    (link_out),
    .link_idle   (link_idle),
    .link_load   (link_load),
    .region_full (region_full)
);

// File: tb/tb_region_link_top.sv
`timescale 1ns/1ps
module tb_region_link_top;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [63:0]   hit_valid = '0;
    logic [639:0]  hit_toa = '0;
    logic [639:0]  hit_tot = '0;
    logic [63:0]   hit_ready;
    logic [1:0]    link_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] rx_word [64];
    int          rx_link [64];
    int          rx_start [64];
    int          rx_n = 0;
    int          bitcnt [2] = '{0, 0};
    logic [31:0] shreg [2];

    // channel, arrival time, time-over-threshold
    localparam logic [25:0] VEC [8] = '{
        {6'd0,  10'd0,   10'd0},
        {6'd63, 10'd1023, 10'd1023},
        {6'd9,  10'd5,   10'd700},
        {6'd18, 10'd512, 10'd1},
        {6'd44, 10'd1,   10'd1022},
        {6'd53, 10'd341, 10'd682},
        {6'd7,  10'd777, 10'd3},
        {6'd30, 10'd100, 10'd200}
    };

    region_link_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_valid (hit_valid),
        .hit_toa   (hit_toa),
        .hit_tot   (hit_tot),
        .hit_ready (hit_ready),
        .link_out  (link_out)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Link deserialiser: a 1 on an idle link opens a 32-bit word.
    always @(negedge clk) begin
        if (!rst_n) begin
            bitcnt[0] = 0;
            bitcnt[1] = 0;
        end else begin
            for (int l = 0; l < 2; l++) begin
                if (bitcnt[l] == 0) begin
                    if (link_out[l]) begin
                        shreg[l]  = 32'd1;
                        bitcnt[l] = 1;
                        if (rx_n < 64) rx_start[rx_n] = cyc;
                    end
                end else begin
                    shreg[l]  = {shreg[l][30:0], link_out[l]};
                    bitcnt[l] = bitcnt[l] + 1;
                    if (bitcnt[l] == 32) begin
                        if (rx_n < 64) begin
                            rx_word[rx_n] = shreg[l];
                            rx_link[rx_n] = l;
                            rx_start[rx_n] = cyc - 31;
                        end
                        rx_n      = rx_n + 1;
                        bitcnt[l] = 0;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic inject(input int ch, input int toa, input int tot, output int acc);
        int guard;
        guard = 0;
        @(negedge clk);
        hit_toa[ch*10 +: 10] = 10'(toa);
        hit_tot[ch*10 +: 10] = 10'(tot);
        hit_valid[ch] = 1'b1;
        #1;
        while (!hit_ready[ch] && guard < 600) begin
            @(negedge clk);
            #1;
            guard++;
        end
        @(posedge clk);
        @(negedge clk);
        acc = cyc;
        hit_valid[ch] = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        int g;
        g = 0;
        while (rx_n < n && g < 400) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic check_word(input int k, input int ch, input int toa,
                              input int tot, input int loss);
        logic [31:0] w;
        w = rx_word[k];
        check(w[31] == 1'b1, "R1", "marker", int'(w[31]), 1);
        check(int'(w[30:25]) == ch, "R1", "channel", int'(w[30:25]), ch);
        check(int'(w[24:15]) == toa, "R1", "arrival", int'(w[24:15]), toa);
        check(int'(w[14:5]) == tot, "R1", "tot", int'(w[14:5]), tot);
        check(int'(w[4:1]) == loss, "R9", "stall count", int'(w[4:1]), loss);
        check((^w) == 1'b0, "R2", "parity", int'(^w), 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        int acc, d0, d1, d2, base;
        // R10: reset state
        repeat (3) @(negedge clk);
        check(link_out == 2'b00, "R10", "links in reset", int'(link_out), 0);
        check(hit_ready == '0, "R10", "ready in reset", 0, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(link_out == 2'b00, "R3", "idle link", int'(link_out), 0);

        // Table: single hits on an idle block.
        base = 0;
        for (int i = 0; i < 8; i++) begin
            inject(int'(VEC[i][25:20]), int'(VEC[i][19:10]), int'(VEC[i][9:0]), acc);
            wait_rx(base + 1);
            check(rx_n == base + 1, "R10", "word count", rx_n, base + 1);
            check_word(base, int'(VEC[i][25:20]), int'(VEC[i][19:10]),
                       int'(VEC[i][9:0]), 0);
            check(rx_link[base] == 0, "R4", "link 0 when both idle", rx_link[base], 0);
            check(rx_start[base] == acc + 1, "R5", "start latency",
                  rx_start[base], acc + 1);
            base++;
            repeat (3) @(negedge clk);
        end
        check(link_out == 2'b00, "R3", "idle after words", int'(link_out), 0);

        // Reset again: arbiters restart at index 0.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(link_out == 2'b00, "R10", "links in second reset", int'(link_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8 / R4: three regions at once.
        fork
            inject(58, 11, 22, d0);
            inject(20, 33, 44, d1);
            inject(41, 55, 66, d2);
        join
        wait_rx(base + 3);
        check_word(base, 20, 33, 44, 0);
        check_word(base + 1, 41, 55, 66, 0);
        check_word(base + 2, 58, 11, 22, 0);
        check(rx_link[base] == 0, "R4", "first on link 0", rx_link[base], 0);
        check(rx_link[base + 1] == 1, "R4", "second on link 1", rx_link[base + 1], 1);
        check(rx_start[base + 1] == rx_start[base] + 1, "R4", "one start per cycle",
              rx_start[base + 1], rx_start[base] + 1);
        check(rx_link[base + 2] == 0, "R3", "link 0 reused", rx_link[base + 2], 0);
        check(rx_start[base + 2] == rx_start[base] + 33, "R3", "idle gap",
              rx_start[base + 2], rx_start[base] + 33);
        base += 3;

        // R6: rotating order inside region 3, then wrap.
        fork
            inject(27, 1, 2, d0);
            inject(25, 3, 4, d1);
            inject(30, 5, 6, d2);
        join
        wait_rx(base + 3);
        check_word(base, 25, 3, 4, 0);
        check_word(base + 1, 27, 1, 2, 0);
        check_word(base + 2, 30, 5, 6, 0);
        base += 3;
        fork
            inject(24, 7, 8, d0);
            inject(31, 9, 10, d1);
        join
        wait_rx(base + 2);
        check(int'(rx_word[base][30:25]) == 31, "R6", "wrap first",
              int'(rx_word[base][30:25]), 31);
        check(int'(rx_word[base + 1][30:25]) == 24, "R6", "wrap second",
              int'(rx_word[base + 1][30:25]), 24);
        base += 2;
        repeat (5) @(negedge clk);

        // R7 / R9: seven hits into region 4 fill its FIFO.
        fork
            inject(32, 100, 1, d0);
            inject(33, 101, 2, d0);
            inject(34, 102, 3, d0);
            inject(35, 103, 4, d0);
            inject(36, 104, 5, d0);
            inject(37, 105, 6, d0);
            inject(38, 106, 7, d0);
            begin
                repeat (15) @(negedge clk);
                #1;
                check(hit_ready[39:32] == '0, "R7", "ready low while full",
                      int'(hit_ready[39:32]), 0);
                check(hit_valid[38] == 1'b1, "R7", "hit still pending",
                      int'(hit_valid[38]), 1);
            end
        join
        wait_rx(base + 7);
        for (int k = 0; k < 6; k++) check_word(base + k, 32 + k, 100 + k, 1 + k, 0);
        check_word(base + 6, 38, 106, 7, 15);
        base += 7;

        // R10: nothing extra appears.
        repeat (100) @(negedge clk);
        check(rx_n == 23, "R10", "total words", rx_n, 23);
        check(link_out == 2'b00, "R3", "final idle", int'(link_out), 0);
        done = 1'b1;
        finish_run();
    end
endmodule